// File: doc/BRIEF.md
# Linked-List Scatter-Gather DMA Engine

This block copies data between the card's local memory and host memory. Software places a chain of descriptors in host memory. Each descriptor is three consecutive little-endian 32-bit words: the local address, the host address, and a byte length. Bit 31 of the length word flags the final descriptor. Software writes the head address of the chain into the list pointer for the wanted direction, sets that direction's enable bit, and writes a start code to the control register. The engine then fetches each descriptor and moves the data one 32-bit word per beat. It follows the chain until it meets the final flag.

The engine has two directions. The read direction copies host memory into local memory. The write direction copies local memory into host memory. Only one chain runs at a time. When a chain finishes cleanly, the engine emits a one-cycle completion pulse for that direction. Descriptor faults and data faults set sticky error bits in the status register and raise an error flag. A stop command halts the engine once the current beat is done. A cancel command clears the engine and all of its status at once.

Every descriptor fetch and every data beat goes through a single request port. A request is held until the memory acknowledges it. An error response aborts the chain.

Top module: `sgdma_engine`

## Requirements
- R1: After reset the status register reads 0, `mem_req` is low, both completion pulses are low and `err_flag` is low.
- R2: Status bits are: bit 0 read busy, bit 1 write busy, bit 2 read data error, bit 3 write data error, bit 4 linked-list error. At most one busy bit is set, and it is set for the whole time the started chain is active.
- R3: A descriptor is fetched as three consecutive host words at list pointer +0, +4 and +8. These are the local address, the host address and the length. Each request is held with a stable address until `mem_ack`.
- R4: The read direction (start code 1) copies host words to local memory. The write direction (start code 2) copies local words to host memory. Each beat moves one 32-bit word unchanged. Both addresses advance by 4 per beat. The number of beats is the length in bits 30:0, divided by 4 and rounded up.
- R5: After a descriptor whose length bit 31 is 0, the next descriptor is fetched at list pointer +12. A descriptor with bit 31 set ends the chain.
- R6: When a chain ends without error, the engine emits a one-cycle pulse on `done_rd` (read) or `done_wr` (write), and both busy bits are clear in that cycle.
- R7: A start code is ignored, with no memory request and no status change, in two cases: its enable bit is clear (enable bit 0 for read, bit 1 for write), or a chain is already active.
- R8: The chain aborts with status bit 4 set, busy cleared and `err_flag` high in two cases: a descriptor fetch returns `mem_err`, or a descriptor has a length of zero.
- R9: A data beat that returns `mem_err` aborts the chain. It sets status bit 2 in the read direction or bit 3 in the write direction, and busy clears.
- R10: Control code 0 (cancel) drops any request in the following cycle. From that cycle on, the busy bits, all error bits and `err_flag` read 0.
- R11: Control code 4 (stop) during a chain lets the current beat finish and then halts. Busy is cleared, error bits are unchanged and no completion pulse is emitted.
- R12: The register offsets are control 0x00, enable 0x04, status 0x08, read list head 0x0C and write list head 0x10. The enable and list head registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory request valid, held until acknowledged |
| mem_we | output | 1 | 1 = write beat, 0 = read |
| mem_host | output | 1 | 1 = host memory space, 0 = local memory space |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_err | input | 1 | Error response, valid with mem_ack |
| done_rd | output | 1 | One-cycle pulse: read chain completed |
| done_wr | output | 1 | One-cycle pulse: write chain completed |
| err_flag | output | 1 | High while any error bit is set |

## Verification
The assertions check the following on every cycle:
- at most one busy bit is set;
- a request stays stable until it is acknowledged;
- no request is issued while idle;
- a completion pulse lasts one cycle and coincides with idle;
- a linked-list fault leaves the engine idle with bit 4 set;
- cancel clears everything in the next cycle.

The bench scenarios are the only place that shows whether data lands at the right addresses with the rounded beat count, and that the chain is followed across descriptors. They also show that disabled or overlapping starts leave memory and status alone. Finally, they show that a stop leaves a clean prefix of the copied block with no completion pulse.

// File: rtl/sgdma_pkg.sv
// Shared constants and types for the scatter-gather DMA engine.
// Assumes byte-addressed registers on a 5-bit offset bus.
package sgdma_pkg;
    localparam int unsigned REG_AW = 5;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h00;
    localparam logic [REG_AW-1:0] OFS_ENA   = 5'h04;
    localparam logic [REG_AW-1:0] OFS_STAT  = 5'h08;
    localparam logic [REG_AW-1:0] OFS_RHEAD = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_WHEAD = 5'h10;

    localparam logic [31:0] CMD_CANCEL = 32'd0;
    localparam logic [31:0] CMD_READ   = 32'd1;
    localparam logic [31:0] CMD_WRITE  = 32'd2;
    localparam logic [31:0] CMD_STOP   = 32'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SRC   = 2'd2,
        ST_DST   = 2'd3
    } walk_st_t;
endpackage

// File: rtl/sgdma_regs.sv
// Register file of the DMA engine: control decode, enable, list heads and
// sticky error bits. Start and stop commands are qualified here, so the
// walker only ever sees legal commands. Assumes one register write per cycle.
module sgdma_regs #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [sgdma_pkg::REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic                        busy_rd,
    input  logic                        busy_wr,
    input  logic                        set_rerr,
    input  logic                        set_werr,
    input  logic                        set_lerr,
    output logic                        start_rd,
    output logic                        start_wr,
    output logic                        cancel,
    output logic                        stop,
    output logic [DATA_W-1:0]           rd_head,
    output logic [DATA_W-1:0]           wr_head,
    output logic [2:0]                  err_bits
);
    import sgdma_pkg::*;

    logic [1:0] ena_q;
    logic       ctrl_hit;
    logic       idle;

    // Command decode, qualified by enable and engine idleness.
    always_comb begin
        ctrl_hit = reg_we && (reg_addr == OFS_CTRL);
        idle     = !busy_rd && !busy_wr;
        start_rd = ctrl_hit && (reg_wdata == DATA_W'(CMD_READ))  && ena_q[0] && idle;
        start_wr = ctrl_hit && (reg_wdata == DATA_W'(CMD_WRITE)) && ena_q[1] && idle;
        stop     = ctrl_hit && (reg_wdata == DATA_W'(CMD_STOP))  && !idle;
        cancel   = ctrl_hit && (reg_wdata == DATA_W'(CMD_CANCEL));
    end

    // Writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q   <= '0;
            rd_head <= '0;
            wr_head <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_ENA:   ena_q   <= reg_wdata[1:0];
                OFS_RHEAD: rd_head <= reg_wdata;
                OFS_WHEAD: wr_head <= reg_wdata;
                default:   ;
            endcase
        end
    end

    // Sticky error bits {list, write, read}; cancel has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || cancel) begin
            err_bits <= '0;
        end else begin
            err_bits <= err_bits | {set_lerr, set_werr, set_rerr};
        end
    end

    // Read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_ENA:   reg_rdata = DATA_W'(ena_q);
            OFS_STAT:  reg_rdata = DATA_W'({err_bits, busy_wr, busy_rd});
            OFS_RHEAD: reg_rdata = rd_head;
            OFS_WHEAD: reg_rdata = wr_head;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sgdma_walker.sv
// Descriptor walker: fetches three-word descriptors, then runs the
// per-descriptor loop of source-read / destination-write beats. It follows
// the chain until the last-link flag is seen. Assumes a single outstanding
// request that is held until mem_ack, and start/stop already qualified.
module sgdma_walker #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic              cancel,
    input  logic              stop,
    input  logic [DATA_W-1:0] rd_head,
    input  logic [DATA_W-1:0] wr_head,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_host,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              busy_rd,
    output logic              busy_wr,
    output logic              set_rerr,
    output logic              set_werr,
    output logic              set_lerr,
    output logic              done_rd,
    output logic              done_wr
);
    import sgdma_pkg::*;

    localparam int unsigned BB    = DATA_W / 8;
    localparam int unsigned SHIFT = $clog2(BB);
    localparam logic [DATA_W-1:0] STEP      = DATA_W'(BB);
    localparam logic [DATA_W-1:0] DESC_STEP = DATA_W'(3 * BB);

    walk_st_t          st;
    logic              dir_wr;
    logic [DATA_W-1:0] list_ptr;
    logic [1:0]        widx;
    logic [DATA_W-1:0] loc_a;
    logic [DATA_W-1:0] host_a;
    logic [DATA_W-1:0] left_q;
    logic              last_q;
    logic [DATA_W-1:0] buf_q;
    logic              stop_q;
    logic              stop_eff;
    logic              len_zero;
    logic              fetch_bad;
    logic              data_bad;
    logic [DATA_W-1:0] beats_nx;

    // Request generation from the current state.
    always_comb begin
        mem_req   = (st != ST_IDLE);
        mem_we    = (st == ST_DST);
        mem_wdata = buf_q;
        case (st)
            ST_FETCH: begin
                mem_host = 1'b1;
                mem_addr = list_ptr + (DATA_W'(widx) << SHIFT);
            end
            ST_SRC: begin
                mem_host = !dir_wr;
                mem_addr = dir_wr ? loc_a : host_a;
            end
            ST_DST: begin
                mem_host = dir_wr;
                mem_addr = dir_wr ? host_a : loc_a;
            end
            default: begin
                mem_host = 1'b0;
                mem_addr = '0;
            end
        endcase
    end

    // Fault and status derivation for the register block.
    always_comb begin
        busy_rd   = (st != ST_IDLE) && !dir_wr;
        busy_wr   = (st != ST_IDLE) && dir_wr;
        stop_eff  = stop_q || stop;
        len_zero  = (mem_rdata[DATA_W-2:0] == '0);
        beats_nx  = ({1'b0, mem_rdata[DATA_W-2:0]} + DATA_W'(BB - 1)) >> SHIFT;
        fetch_bad = (st == ST_FETCH) && mem_ack && (mem_err || ((widx == 2'd2) && len_zero));
        data_bad  = ((st == ST_SRC) || (st == ST_DST)) && mem_ack && mem_err;
        set_lerr  = fetch_bad && !cancel;
        set_rerr  = data_bad && !dir_wr && !cancel;
        set_werr  = data_bad && dir_wr && !cancel;
    end

    // Walker state machine with descriptor and beat bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            dir_wr   <= 1'b0;
            list_ptr <= '0;
            widx     <= '0;
            loc_a    <= '0;
            host_a   <= '0;
            left_q   <= '0;
            last_q   <= 1'b0;
            buf_q    <= '0;
            stop_q   <= 1'b0;
            done_rd  <= 1'b0;
            done_wr  <= 1'b0;
        end else begin
            done_rd <= 1'b0;
            done_wr <= 1'b0;
            if (stop) stop_q <= 1'b1;
            if (cancel) begin
                st     <= ST_IDLE;
                stop_q <= 1'b0;
            end else begin
                case (st)
                    ST_IDLE: begin
                        if (start_rd || start_wr) begin
                            dir_wr   <= start_wr;
                            list_ptr <= start_wr ? wr_head : rd_head;
                            widx     <= '0;
                            stop_q   <= 1'b0;
                            st       <= ST_FETCH;
                        end
                    end
                    ST_FETCH: begin
                        if (mem_ack) begin
                            if (fetch_bad) begin
                                st <= ST_IDLE;
                            end else begin
                                case (widx)
                                    2'd0:    loc_a  <= mem_rdata;
                                    2'd1:    host_a <= mem_rdata;
                                    default: begin
                                        last_q <= mem_rdata[DATA_W-1];
                                        left_q <= beats_nx;
                                    end
                                endcase
                                if (stop_eff) begin
                                    st <= ST_IDLE;
                                end else if (widx == 2'd2) begin
                                    widx     <= '0;
                                    list_ptr <= list_ptr + DESC_STEP;
                                    st       <= ST_SRC;
                                end else begin
                                    widx <= widx + 2'd1;
                                end
                            end
                        end
                    end
                    ST_SRC: begin
                        if (mem_ack) begin
                            buf_q <= mem_rdata;
                            st    <= mem_err ? ST_IDLE : ST_DST;
                        end
                    end
                    default: begin
                        if (mem_ack) begin
                            if (mem_err) begin
                                st <= ST_IDLE;
                            end else begin
                                loc_a  <= loc_a + STEP;
                                host_a <= host_a + STEP;
                                left_q <= left_q - DATA_W'(1);
                                if ((left_q == DATA_W'(1)) && last_q) begin
                                    done_rd <= !dir_wr;
                                    done_wr <= dir_wr;
                                    st      <= ST_IDLE;
                                end else if (stop_eff) begin
                                    st <= ST_IDLE;
                                end else if (left_q == DATA_W'(1)) begin
                                    widx <= '0;
                                    st   <= ST_FETCH;
                                end else begin
                                    st <= ST_SRC;
                                end
                            end
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/sgdma_engine.sv
// Top of the scatter-gather DMA engine: joins the register block and the
// descriptor walker. Assumes a memory port with one outstanding request and
// 32-bit little-endian words whose byte order is passed through untouched.
module sgdma_engine #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [sgdma_pkg::REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic [DATA_W-1:0]            reg_rdata,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic                         mem_host,
    output logic [DATA_W-1:0]            mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    input  logic                         mem_ack,
    input  logic [DATA_W-1:0]            mem_rdata,
    input  logic                         mem_err,
    output logic                         done_rd,
    output logic                         done_wr,
    output logic                         err_flag
);
    logic              w_busy_rd, w_busy_wr;
    logic              w_set_rerr, w_set_werr, w_set_lerr;
    logic              c_start_rd, c_start_wr, c_cancel, c_stop;
    logic [DATA_W-1:0] c_rd_head, c_wr_head;
    logic [2:0]        c_err_bits;

    sgdma_regs #(.DATA_W(DATA_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy_rd  (w_busy_rd),
        .busy_wr  (w_busy_wr),
        .set_rerr (w_set_rerr),
        .set_werr (w_set_werr),
        .set_lerr (w_set_lerr),
        .start_rd (c_start_rd),
        .start_wr (c_start_wr),
        .cancel   (c_cancel),
        .stop     (c_stop),
        .rd_head  (c_rd_head),
        .wr_head  (c_wr_head),
        .err_bits (c_err_bits)
    );

    sgdma_walker #(.DATA_W(DATA_W)) walk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_rd (c_start_rd),
        .start_wr (c_start_wr),
        .cancel   (c_cancel),
        .stop     (c_stop),
        .rd_head  (c_rd_head),
        .wr_head  (c_wr_head),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_host (mem_host),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .mem_err  (mem_err),
        .busy_rd  (w_busy_rd),
        .busy_wr  (w_busy_wr),
        .set_rerr (w_set_rerr),
        .set_werr (w_set_werr),
        .set_lerr (w_set_lerr),
        .done_rd  (done_rd),
        .done_wr  (done_wr)
    );

    // Summary error flag for the interrupt logic.
    assign err_flag = |c_err_bits;
endmodule

// File: rtl/sgdma_chk.sv
// Protocol and status checker for sgdma_engine, bound to every instance.
// Assumes the internal busy, cancel and error signals of the top.
module sgdma_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cancel,
    input logic              busy_rd,
    input logic              busy_wr,
    input logic              set_lerr,
    input logic [2:0]        err_bits,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic              done_rd,
    input logic              done_wr,
    input logic              err_flag
);
    // R2: never both directions busy
    p_busy_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_wr, busy_rd}));

    // R3: a pending request holds until acknowledged
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !cancel) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6: completion is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_rd || done_wr) |=> !(done_rd || done_wr));

    // R6: completion coincides with idle
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_rd || done_wr) |-> (!busy_rd && !busy_wr));

    // R7: no memory traffic while idle
    p_idle_noreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_rd && !busy_wr) |-> !mem_req);

    // R8: list fault aborts with bit 4 and the flag set
    p_lerr_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_lerr |=> (!busy_rd && !busy_wr && err_bits[2] && err_flag));

    // R10: cancel clears everything next cycle
    p_cancel_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> (!busy_rd && !busy_wr && (err_bits == 3'b000) && !err_flag && !mem_req));
endmodule

bind sgdma_engine sgdma_chk #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cancel  (c_cancel),
    .busy_rd (w_busy_rd),
    .busy_wr (w_busy_wr),
    .set_lerr(w_set_lerr),
    .err_bits(c_err_bits),
    .mem_req (mem_req),
    .mem_ack (mem_ack),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .done_rd (done_rd),
    .done_wr (done_wr),
    .err_flag(err_flag)
);

// File: tb/sgdma_engine_tb_top.sv
`timescale 1ns/1ps
module sgdma_engine_tb_top;
    import sgdma_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_host;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack, mem_err;
    logic [31:0] mem_rdata;
    logic        done_rd, done_wr, err_flag;

    logic [31:0] host_mem [256];
    logic [31:0] loc_mem  [256];
    logic        pl_we = 1'b0, pl_host = 1'b0;
    logic [7:0]  pl_idx = '0;
    logic [31:0] pl_data = '0;

    int  total = 0;
    int  bad = 0;
    int  req_cycles = 0;
    bit  exp_q[$];
    bit  prev_done = 1'b0;
    bit  exp_dir;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    sgdma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_host(mem_host), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .done_rd(done_rd), .done_wr(done_wr), .err_flag(err_flag)
    );

    // Memory model: one-cycle acknowledge, error for any address with bit 20 set.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
            for (int i = 0; i < 256; i++) begin host_mem[i] = '0; loc_mem[i] = '0; end
        end else begin
            if (pl_we) begin
                if (pl_host) host_mem[pl_idx] = pl_data; else loc_mem[pl_idx] = pl_data;
            end
            if (mem_req) req_cycles++;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                mem_err <= mem_addr[20];
                if (!mem_addr[20]) begin
                    if (mem_we) begin
                        if (mem_host) host_mem[mem_addr[9:2]] = mem_wdata;
                        else          loc_mem[mem_addr[9:2]]  = mem_wdata;
                    end else begin
                        mem_rdata <= mem_host ? host_mem[mem_addr[9:2]] : loc_mem[mem_addr[9:2]];
                    end
                end
            end else begin
                mem_ack <= 1'b0; mem_err <= 1'b0;
            end
        end
    end

    // Scoreboard monitor: each completion pulse must match the next expected direction.
    always @(negedge clk) begin
        if (rst_n && (done_rd || done_wr)) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R6 unexpected completion act rd=%0d wr=%0d exp none", done_rd, done_wr);
            end else begin
                exp_dir = exp_q.pop_front();
                if (done_wr != exp_dir || done_rd == exp_dir) begin
                    bad++;
                    $display("FAIL R6 completion direction act wr=%0d exp wr=%0d", done_wr, exp_dir);
                end
            end
            if (prev_done) begin
                total++; bad++;
                $display("FAIL R6 pulse width act=2+ exp=1");
            end
        end
        prev_done <= rst_n && (done_rd || done_wr);
    end

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        report();
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic poke(input bit host, input int idx, input logic [31:0] d);
        @(negedge clk);
        pl_we = 1'b1; pl_host = host; pl_idx = 8'(idx); pl_data = d;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            reg_read(OFS_STAT, s);
            if (s[1:0] == 2'b00) break;
        end
    endtask

    task automatic put_desc(input int word, input logic [31:0] la, input logic [31:0] ha,
                            input logic [31:0] len);
        poke(1'b1, word, la);
        poke(1'b1, word + 1, ha);
        poke(1'b1, word + 2, len);
    endtask

    task automatic expect_done(input bit is_wr);
        exp_q.push_back(is_wr);
    endtask

    initial begin
        logic [31:0] v;
        int k;
        int r0;
        repeat (4) @(negedge clk);
        // R1: reset state
        reg_read(OFS_STAT, v);
        chk("R1 status", v, 32'h0);
        chk("R1 outputs", {28'h0, mem_req, done_rd, done_wr, err_flag}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R12: register map read-back
        reg_write(OFS_RHEAD, 32'h0000_0100);
        reg_write(OFS_WHEAD, 32'h0000_0200);
        reg_write(OFS_ENA, 32'h3);
        reg_read(OFS_RHEAD, v); chk("R12 read head", v, 32'h100);
        reg_read(OFS_WHEAD, v); chk("R12 write head", v, 32'h200);
        reg_read(OFS_ENA, v);   chk("R12 enable", v, 32'h3);

        // Data and descriptors
        poke(1'b1, 8'hC0, 32'hA500_00C0); poke(1'b1, 8'hC1, 32'hA500_00C1);
        poke(1'b1, 8'hE0, 32'hA500_00E0); poke(1'b1, 8'hE1, 32'hA500_00E1);
        put_desc(8'h40, 32'h000, 32'h300, 32'd8);
        put_desc(8'h43, 32'h040, 32'h380, 32'h8000_0006);
        for (int i = 0; i < 3; i++) poke(1'b0, 8'h20 + i, 32'h5A00_0000 + i);
        put_desc(8'h80, 32'h080, 32'h340, 32'h8000_000C);

        // R4 R5 read chain of two descriptors
        expect_done(1'b0);
        reg_write(OFS_CTRL, CMD_READ);
        reg_read(OFS_STAT, v);
        chk("R2 read busy", v, 32'h1);
        wait_idle();
        chk("R4 desc0 word0", loc_mem[8'h00], 32'hA500_00C0);
        chk("R4 desc0 word1", loc_mem[8'h01], 32'hA500_00C1);
        chk("R5 desc1 word0", loc_mem[8'h10], 32'hA500_00E0);
        chk("R4 rounded len word1", loc_mem[8'h11], 32'hA500_00E1);
        chk("R4 no beat past length", loc_mem[8'h12], 32'h0);
        chk("R5 chain stops at last", loc_mem[8'h02], 32'h0);

        // R4 write chain
        expect_done(1'b1);
        reg_write(OFS_CTRL, CMD_WRITE);
        reg_read(OFS_STAT, v);
        chk("R2 write busy", v, 32'h2);
        wait_idle();
        for (int i = 0; i < 3; i++) chk("R4 write dir data", host_mem[8'hD0 + i], 32'h5A00_0000 + i);
        chk("R4 write beyond", host_mem[8'hD3], 32'h0);

        // R7 disabled direction ignored
        reg_write(OFS_ENA, 32'h1);
        r0 = req_cycles;
        reg_write(OFS_CTRL, CMD_WRITE);
        repeat (5) @(negedge clk);
        reg_read(OFS_STAT, v);
        chk("R7 disabled status", v, 32'h0);
        chk("R7 disabled no request", 32'(req_cycles - r0), 32'h0);
        reg_write(OFS_ENA, 32'h3);

        // R8 zero length descriptor
        put_desc(8'h60, 32'h000, 32'h300, 32'h8000_0000);
        reg_write(OFS_RHEAD, 32'h180);
        reg_write(OFS_CTRL, CMD_READ);
        wait_idle();
        reg_read(OFS_STAT, v);
        chk("R8 zero length status", v, 32'h10);
        chk("R8 err flag", {31'h0, err_flag}, 32'h1);

        // R10 cancel clears errors
        reg_write(OFS_CTRL, CMD_CANCEL);
        reg_read(OFS_STAT, v);
        chk("R10 cancel status", v, 32'h0);
        chk("R10 cancel flag", {31'h0, err_flag}, 32'h0);

        // R8 fetch error
        reg_write(OFS_RHEAD, 32'h0010_0100);
        reg_write(OFS_CTRL, CMD_READ);
        wait_idle();
        reg_read(OFS_STAT, v);
        chk("R8 fetch error status", v, 32'h10);
        reg_write(OFS_CTRL, CMD_CANCEL);

        // R9 data errors in each direction
        put_desc(8'h70, 32'h000, 32'h0010_0000, 32'h8000_0004);
        reg_write(OFS_RHEAD, 32'h1C0);
        reg_write(OFS_CTRL, CMD_READ);
        wait_idle();
        reg_read(OFS_STAT, v);
        chk("R9 read data error", v, 32'h04);
        reg_write(OFS_CTRL, CMD_CANCEL);
        put_desc(8'h78, 32'h0010_0000, 32'h300, 32'h8000_0004);
        reg_write(OFS_WHEAD, 32'h1E0);
        reg_write(OFS_CTRL, CMD_WRITE);
        wait_idle();
        reg_read(OFS_STAT, v);
        chk("R9 write data error", v, 32'h08);
        reg_write(OFS_CTRL, CMD_CANCEL);

        // R11 stop mid-chain, R7 start while busy
        for (int i = 0; i < 32; i++) poke(1'b1, i, 32'hC0DE_0000 + i);
        put_desc(8'h90, 32'h200, 32'h000, 32'h8000_0080);
        reg_write(OFS_RHEAD, 32'h240);
        reg_write(OFS_CTRL, CMD_READ);
        repeat (10) @(negedge clk);
        reg_write(OFS_CTRL, CMD_WRITE);
        reg_read(OFS_STAT, v);
        chk("R7 start while busy ignored", v, 32'h1);
        reg_write(OFS_CTRL, CMD_STOP);
        wait_idle();
        repeat (3) @(negedge clk);
        reg_read(OFS_STAT, v);
        chk("R11 stop status", v, 32'h0);
        k = 0;
        while (k < 32 && loc_mem[8'h80 + k] == 32'hC0DE_0000 + k) k++;
        chk("R11 partial copy", {31'h0, (k > 0 && k < 32)}, 32'h1);
        for (int i = k; i < 32; i++) chk("R11 no beat after stop", loc_mem[8'h80 + i], 32'h0);

        // R10 cancel in flight
        reg_write(OFS_RHEAD, 32'h100);
        reg_write(OFS_CTRL, CMD_READ);
        repeat (3) @(negedge clk);
        reg_write(OFS_CTRL, CMD_CANCEL);
        reg_read(OFS_STAT, v);
        chk("R10 cancel in flight status", v, 32'h0);
        chk("R10 cancel drops request", {31'h0, mem_req}, 32'h0);

        repeat (5) @(negedge clk);
        chk("R6 all completions seen", 32'(exp_q.size()), 32'h0);
        report();
    end
endmodule